// File: doc/BRIEF.md
# Serial Character Receiver with Bus-Break Detection

This block receives asynchronous serial characters on a single line input. It oversamples the line 16 times per bit, using a tick from a two-stage programmable divider. Each bit value is decided by a vote among three samples taken near the middle of the bit. Characters are eight data bits sent least significant bit first, framed by a low start bit and a high stop bit. A received character is strobed for one cycle and stays readable until the next one arrives. A stop bit that samples low raises a sticky framing-error flag.

An optional break detector serves slave nodes on a single-wire vehicle bus. When it is enabled, the block counts how many consecutive bit periods the line stays low, starting at the start bit. A run that reaches 13 bit periods, or 14 if the long threshold is selected, raises a sticky break flag instead of delivering a character. A zero data byte is only about ten low bit periods long even with a slow clock, so it stays well below either threshold. After a break or a framing error, the receiver waits for the line to return high before it looks for another start bit.

A small register interface reaches three locations. The first is a shared data location: a read returns the last received byte, and a write loads a separate transmit holding byte. The second is a control byte holding the divider and break settings. The third is a status byte whose flags are cleared by writing ones. Reset leaves both data bytes unchanged.

Top module: `serial_rx_brk`

## Requirements
- R1: After reset the control byte reads 0x00 (break detection off), the status byte reads 0x00, both flag outputs are low and no strobe occurs.
- R2: A frame made of a low start bit, eight data bits sent LSB first and a high stop bit produces exactly one `rx_strobe` pulse. After it, a read of address 0 returns the data byte.
- R3: A low pulse on an idle line that has ended before the 7th sample after its falling edge is rejected as a false start: no strobe, no flag.
- R4: The sample tick period is B × 2^E clocks and a bit lasts 16 ticks. E is control bits 2:0, and B is 1, 3, 4 or 13 for control bits 5:4 = 00, 01, 10, 11. Control bit 3 always reads 0.
- R5: With break detection off (control bit 7 = 0), a low stop bit sets the framing flag (status bit 0, `frame_err`) and gives no strobe. This holds for any length of low line, and the break flag never sets.
- R6: With control bit 7 = 1 and bit 6 = 0, a low run of 13 bit periods sets the break flag (status bit 1, `brk_det`) with no strobe and no framing flag. A run of 12 bit periods sets only the framing flag.
- R7: With control bits 7 and 6 both 1, a run of 14 bit periods is needed for the break flag. A run of 13 sets only the framing flag.
- R8: With break detection on, a 0x00 character with a high stop bit is received as normal data and does not set the break flag.
- R9: After a break, the receiver ignores the line while it stays low. It needs the line high before it accepts a new start bit, and the next correct frame is then received.
- R10: Both status flags are sticky. Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R11: A write to address 0 loads `tx_hold` and does not change the received byte that address 0 reads back.
- R12: Reset changes neither the received byte nor `tx_hold`, and it returns the control byte to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| bus_we | input | 1 | Write enable for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| rx_i | input | 1 | Serial line input, idle high |
| rx_strobe | output | 1 | One-cycle pulse when a character is received |
| frame_err | output | 1 | Sticky framing-error flag |
| brk_det | output | 1 | Sticky break flag |
| tx_hold | output | 8 | Transmit holding byte written through address 0 |

## Verification
The hardest cases to reach are low runs that end exactly one bit period before or at the break threshold, in each threshold mode. A second hard case is a line held low well past a break, which must not produce a second event. The bench uses the fastest divisor setting and holds the line low for exact whole numbers of bit periods (12, 13, 14 and 30). Because the hold lengths are whole bit periods, the sample points fall clearly inside or outside the run. The bench then reads the status byte and checks the strobe count.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_STOP,
      ST_BRK,
      ST_WAITH
   } rx_st_e;

   // First-stage divide ratio chosen by the 2-bit select field.
   function automatic logic [3:0] pre1_ratio(input logic [1:0] sel);
      case (sel)
         2'd0:    return 4'd1;
         2'd1:    return 4'd3;
         2'd2:    return 4'd4;
         default: return 4'd13;
      endcase
   endfunction

endpackage

// File: rtl/srx_baud.sv
module srx_baud
   import serial_rx_pkg::*;
#(
   parameter int PRE2_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        pre1_sel,
   input  logic [PRE2_W-1:0] pre2_exp,
   output logic              tick_o
);

   localparam int MAX_EXP = (1 << PRE2_W) - 1;
   localparam int DIV_W   = 4 + MAX_EXP;

   if (PRE2_W < 1 || PRE2_W > 4) begin : g_bad_pre2
      $error("srx_baud: PRE2_W must be 1..4");
   end

   logic [DIV_W-1:0] limit;
   logic [DIV_W-1:0] cnt;

   always_comb begin
      limit = (DIV_W'(pre1_ratio(pre1_sel)) << pre2_exp) - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         tick_o <= 1'b0;
      end else if (cnt >= limit) begin
         cnt    <= '0;
         tick_o <= 1'b1;
      end else begin
         cnt    <= cnt + 1'b1;
         tick_o <= 1'b0;
      end
   end

   // R4: with a divide ratio above one, ticks never come back to back
   p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && limit != '0) |=> !tick_o);

endmodule

// File: rtl/srx_core.sv
module srx_core
   import serial_rx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int OVS       = 16,
   parameter int THR_SHORT = 13,
   parameter int THR_LONG  = 14,
   parameter bit VOTE3     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rx_s,
   input  logic              brk_en_i,
   input  logic              long_sel_i,
   output logic              strobe_o,
   output logic              ferr_set_o,
   output logic              brk_set_o,
   output logic [DATA_W-1:0] data_o
);

   localparam int SC_W   = $clog2(OVS);
   localparam int MID    = OVS / 2;
   localparam int RUN_W  = $clog2(THR_LONG + 1);
   localparam int IDX_W  = $clog2(DATA_W);
   localparam logic [SC_W-1:0]  SC_LAST  = SC_W'(OVS - 1);
   localparam logic [SC_W-1:0]  SC_V0    = SC_W'(MID - 1);
   localparam logic [SC_W-1:0]  SC_V1    = SC_W'(MID);
   localparam logic [SC_W-1:0]  SC_V2    = SC_W'(MID + 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("srx_core: OVS must be a power of two, at least 8");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("srx_core: DATA_W must be at least 2");
   end
   if (THR_SHORT <= DATA_W + 2 || THR_LONG < THR_SHORT) begin : g_bad_thr
      $error("srx_core: thresholds must exceed a full zero character");
   end

   rx_st_e            st;
   logic [SC_W-1:0]   sc;
   logic [2:0]        vote;
   logic [IDX_W-1:0]  bit_idx;
   logic [RUN_W-1:0]  run_cnt;
   logic [RUN_W-1:0]  run_next;
   logic [RUN_W-1:0]  thr;
   logic              alive;
   logic              bit_val;
   logic              end_bit;
   logic              take;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] data_q;

   if (VOTE3) begin : g_vote3
      assign bit_val = (vote[0] & vote[1]) | (vote[0] & vote[2]) | (vote[1] & vote[2]);
   end else begin : g_vote1
      assign bit_val = vote[1];
   end

   always_comb begin
      end_bit  = tick_i && (sc == SC_LAST);
      run_next = run_cnt + 1'b1;
      thr      = long_sel_i ? RUN_W'(THR_LONG) : RUN_W'(THR_SHORT);
      take     = end_bit && (st == ST_STOP) && bit_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         sc         <= '0;
         vote       <= '1;
         bit_idx    <= '0;
         run_cnt    <= '0;
         alive      <= 1'b0;
         strobe_o   <= 1'b0;
         ferr_set_o <= 1'b0;
         brk_set_o  <= 1'b0;
      end else begin
         strobe_o   <= 1'b0;
         ferr_set_o <= 1'b0;
         brk_set_o  <= 1'b0;
         if (tick_i) begin
            case (st)
               ST_IDLE: begin
                  if (!rx_s) begin
                     st      <= ST_START;
                     sc      <= '0;
                     alive   <= 1'b1;
                     run_cnt <= '0;
                  end
               end
               ST_WAITH: begin
                  if (rx_s) st <= ST_IDLE;
               end
               default: begin
                  sc <= sc + 1'b1;
                  if (sc == SC_V0) vote[0] <= rx_s;
                  if (sc == SC_V1) vote[1] <= rx_s;
                  if (sc == SC_V2) vote[2] <= rx_s;
                  if (sc == SC_LAST) begin
                     case (st)
                        ST_START: begin
                           if (bit_val) begin
                              st <= ST_IDLE;
                           end else begin
                              st      <= ST_DATA;
                              bit_idx <= '0;
                              run_cnt <= RUN_W'(1);
                           end
                        end
                        ST_DATA: begin
                           bit_idx <= bit_idx + 1'b1;
                           if (bit_val) alive <= 1'b0;
                           else if (alive) run_cnt <= run_next;
                           if (bit_idx == IDX_LAST) st <= ST_STOP;
                        end
                        ST_STOP: begin
                           if (bit_val) begin
                              strobe_o <= 1'b1;
                              st       <= ST_IDLE;
                           end else if (brk_en_i && alive) begin
                              run_cnt <= run_next;
                              if (run_next >= thr) begin
                                 brk_set_o <= 1'b1;
                                 st        <= ST_WAITH;
                              end else begin
                                 st <= ST_BRK;
                              end
                           end else begin
                              ferr_set_o <= 1'b1;
                              st         <= ST_WAITH;
                           end
                        end
                        ST_BRK: begin
                           if (bit_val) begin
                              ferr_set_o <= 1'b1;
                              st         <= ST_IDLE;
                           end else begin
                              run_cnt <= run_next;
                              if (run_next >= thr) begin
                                 brk_set_o <= 1'b1;
                                 st        <= ST_WAITH;
                              end
                           end
                        end
                        default: st <= ST_IDLE;
                     endcase
                  end
               end
            endcase
         end
      end
   end

   // Character storage is deliberately left out of reset.
   always_ff @(posedge clk) begin
      if (end_bit && st == ST_DATA) shreg <= {bit_val, shreg[DATA_W-1:1]};
      if (take) data_q <= shreg;
   end

   assign data_o = data_q;

   // R9: leaving the wait state needs a high line sample
   p_wait_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && $past(st) == ST_WAITH) |-> $past(rx_s));

   // R2: a character strobe only follows a sample tick
   p_strobe_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> $past(tick_i));

endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk
   import serial_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int THR_SHORT   = 13,
   parameter int THR_LONG    = 14,
   parameter bit VOTE3       = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] bus_addr,
   input  logic       bus_we,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       rx_i,
   output logic       rx_strobe,
   output logic       frame_err,
   output logic       brk_det,
   output logic [7:0] tx_hold
);

   localparam int         PRE2_W    = 3;
   localparam logic [1:0] A_DATA    = 2'd0;
   localparam logic [1:0] A_CTRL    = 2'd1;
   localparam logic [1:0] A_STAT    = 2'd2;
   localparam logic [7:0] CTRL_MASK = 8'hF7;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("serial_rx_brk: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [7:0]             ctrl_q;
   logic [7:0]             tx_q;
   logic [7:0]             rx_byte;
   logic                   ferr_q;
   logic                   brk_q;
   logic                   tick;
   logic                   ferr_set;
   logic                   brk_set;
   logic                   stat_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
   end

   srx_baud #(
      .PRE2_W (PRE2_W)
   ) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .pre1_sel (ctrl_q[5:4]),
      .pre2_exp (ctrl_q[2:0]),
      .tick_o   (tick)
   );

   srx_core #(
      .DATA_W    (8),
      .OVS       (OVS),
      .THR_SHORT (THR_SHORT),
      .THR_LONG  (THR_LONG),
      .VOTE3     (VOTE3)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .rx_s       (sync_q[SYNC_STAGES-1]),
      .brk_en_i   (ctrl_q[7]),
      .long_sel_i (ctrl_q[6]),
      .strobe_o   (rx_strobe),
      .ferr_set_o (ferr_set),
      .brk_set_o  (brk_set),
      .data_o     (rx_byte)
   );

   assign stat_wr = bus_we && (bus_addr == A_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ferr_q <= 1'b0;
         brk_q  <= 1'b0;
      end else begin
         if (bus_we && bus_addr == A_CTRL) ctrl_q <= bus_wdata & CTRL_MASK;
         if (ferr_set)                         ferr_q <= 1'b1;
         else if (stat_wr && bus_wdata[0])     ferr_q <= 1'b0;
         if (brk_set)                          brk_q  <= 1'b1;
         else if (stat_wr && bus_wdata[1])     brk_q  <= 1'b0;
      end
   end

   // Transmit holding byte survives reset.
   always_ff @(posedge clk) begin
      if (bus_we && bus_addr == A_DATA) tx_q <= bus_wdata;
   end

   always_comb begin
      case (bus_addr)
         A_DATA:  bus_rdata = rx_byte;
         A_CTRL:  bus_rdata = ctrl_q;
         A_STAT:  bus_rdata = {6'b0, brk_q, ferr_q};
         default: bus_rdata = 8'h00;
      endcase
   end

   assign frame_err = ferr_q;
   assign brk_det   = brk_q;
   assign tx_hold   = tx_q;

   // R5: a break can only be reported with detection enabled
   p_brk_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      brk_set |-> $past(ctrl_q[7]));

   // R10: the break flag holds until a one is written to its bit
   p_brk_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_q && !(stat_wr && bus_wdata[1])) |=> brk_q);

   // R10: the framing flag holds until a one is written to its bit
   p_ferr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ferr_q && !(stat_wr && bus_wdata[0])) |=> ferr_q);

endmodule

// File: tb/serial_rx_brk_tb.sv
module serial_rx_brk_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       rx_i = 1'b1;
   logic       rx_strobe;
   logic       frame_err;
   logic       brk_det;
   logic [7:0] tx_hold;

   int checks = 0;
   int fails = 0;
   int strobes = 0;
   int bit_clks = 16;

   always #4 clk = ~clk;

   serial_rx_brk u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rx_i      (rx_i),
      .rx_strobe (rx_strobe),
      .frame_err (frame_err),
      .brk_det   (brk_det),
      .tx_hold   (tx_hold)
   );

   always @(posedge clk) if (rx_strobe) strobes <= strobes + 1;

   function automatic int ratio(input logic [1:0] sel);
      case (sel)
         2'd0: return 1;
         2'd1: return 3;
         2'd2: return 4;
         default: return 13;
      endcase
   endfunction

   function automatic logic [7:0] exp_status(input bit ferr, input bit brk);
      return {6'b0, brk, ferr};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_bits(input int n);
      repeat (n * bit_clks) @(negedge clk);
   endtask

   task automatic set_cfg(input bit lin, input bit lng, input logic [1:0] p1, input logic [2:0] p2);
      bus_wr(2'd1, {lin, lng, p1, 1'b0, p2});
      bit_clks = 16 * ratio(p1) * (1 << p2);
      wait_bits(1);
   endtask

   task automatic send_frame(input logic [7:0] b, input bit stop);
      rx_i = 1'b0; wait_bits(1);
      for (int i = 0; i < 8; i++) begin
         rx_i = b[i]; wait_bits(1);
      end
      rx_i = stop; wait_bits(1);
      rx_i = 1'b1; wait_bits(3);
   endtask

   task automatic hold_low(input int n);
      rx_i = 1'b0; wait_bits(n);
      rx_i = 1'b1; wait_bits(3);
   endtask

   task automatic good_byte(input string tag, input logic [7:0] b);
      logic [7:0] d;
      int s0;
      s0 = strobes;
      send_frame(b, 1'b1);
      chk({tag, " strobe count"}, strobes - s0, 1);
      bus_rd(2'd0, d);
      chk({tag, " data"}, d, b);
      bus_rd(2'd2, d);
      chk({tag, " status"}, d, exp_status(0, 0));
   endtask

   task automatic run_case(input string tag, input int n, input bit eferr, input bit ebrk);
      logic [7:0] d;
      int s0;
      s0 = strobes;
      hold_low(n);
      bus_rd(2'd2, d);
      chk({tag, " status"}, d, exp_status(eferr, ebrk));
      chk({tag, " no strobe"}, strobes - s0, 0);
      bus_wr(2'd2, 8'h03);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [7:0] last;
      int unsigned seed;
      int s0;
      seed = $urandom(32'd4711);

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1: reset state
      bus_rd(2'd1, d);  chk("R1 ctrl", d, 8'h00);
      bus_rd(2'd2, d);  chk("R1 status", d, 8'h00);
      chk("R1 flags", {frame_err, brk_det}, 2'b00);
      chk("R1 strobes", strobes, 0);

      // R4: control bit 3 reads zero
      bus_wr(2'd1, 8'hFF);
      bus_rd(2'd1, d);  chk("R4 ctrl mask", d, 8'hF7);
      set_cfg(0, 0, 2'd0, 3'd0);

      // R3: short glitch rejected
      s0 = strobes;
      rx_i = 1'b0; repeat (4) @(negedge clk); rx_i = 1'b1;
      wait_bits(3);
      chk("R3 glitch strobe", strobes - s0, 0);
      bus_rd(2'd2, d);  chk("R3 glitch status", d, 8'h00);

      // R2/R5: random bytes, some with a low stop bit
      for (int k = 0; k < 24; k++) begin
         logic [7:0] b;
         bit bad;
         b = 8'($urandom);
         bad = ($urandom % 5) == 0;
         if (!bad) begin
            good_byte("R2 random", b);
            last = b;
         end else begin
            s0 = strobes;
            send_frame(b, 1'b0);
            chk("R5 bad stop strobe", strobes - s0, 0);
            bus_rd(2'd2, d);  chk("R5 bad stop status", d, exp_status(1, 0));
            chk("R5 frame_err port", frame_err, 1);
            bus_wr(2'd2, 8'h01);
         end
      end

      // R4: other divider settings
      set_cfg(0, 0, 2'd1, 3'd1);
      for (int k = 0; k < 4; k++) good_byte("R4 div6", 8'($urandom));
      set_cfg(0, 0, 2'd2, 3'd0);
      good_byte("R4 div4", 8'hC3);
      set_cfg(0, 0, 2'd3, 3'd2);
      good_byte("R4 div52", 8'h96);
      good_byte("R4 div52", 8'h01);
      last = 8'h01;

      set_cfg(0, 0, 2'd0, 3'd0);
      // R5: long low in plain mode never gives a break
      run_case("R5 long low plain", 20, 1, 0);

      // R10: sticky flags and write-one-to-clear
      send_frame(8'h55, 1'b0);
      bus_wr(2'd2, 8'h00);
      bus_rd(2'd2, d);  chk("R10 write zero keeps", d, exp_status(1, 0));
      bus_wr(2'd2, 8'h02);
      bus_rd(2'd2, d);  chk("R10 other bit keeps", d, exp_status(1, 0));
      bus_wr(2'd2, 8'h01);
      bus_rd(2'd2, d);  chk("R10 cleared", d, exp_status(0, 0));

      // R6: short threshold
      set_cfg(1, 0, 2'd0, 3'd0);
      run_case("R6 run12", 12, 1, 0);
      run_case("R6 run13", 13, 0, 1);

      // R8: zero character is data
      good_byte("R8 zero byte", 8'h00);

      // R7: long threshold
      set_cfg(1, 1, 2'd0, 3'd0);
      run_case("R7 run13", 13, 1, 0);
      run_case("R7 run14", 14, 0, 1);
      good_byte("R8 zero byte long", 8'h00);

      // R9: line held low long after a break
      set_cfg(1, 0, 2'd0, 3'd0);
      s0 = strobes;
      rx_i = 1'b0; wait_bits(30);
      bus_rd(2'd2, d);  chk("R9 held low status", d, exp_status(0, 1));
      chk("R9 held low strobe", strobes - s0, 0);
      rx_i = 1'b1; wait_bits(3);
      bus_rd(2'd2, d);  chk("R9 after release", d, exp_status(0, 1));
      bus_wr(2'd2, 8'h03);
      good_byte("R9 next frame", 8'hA5);
      last = 8'hA5;

      // R11: shared data address
      bus_wr(2'd0, 8'h5A);
      chk("R11 tx_hold", tx_hold, 8'h5A);
      bus_rd(2'd0, d);  chk("R11 rx unchanged", d, last);

      // R12: reset keeps data
      bus_wr(2'd0, 8'h3C);
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R12 tx_hold kept", tx_hold, 8'h3C);
      bus_rd(2'd0, d);  chk("R12 rx kept", d, last);
      bus_rd(2'd1, d);  chk("R12 ctrl cleared", d, 8'h00);
      bus_rd(2'd2, d);  chk("R12 status cleared", d, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule